// File: doc/BRIEF.md
# Streaming Uniform Crossover Stage

This block sits in a hardware genetic-algorithm pipeline, between the population manager upstream and the mutation stage downstream. Individuals arrive one after another as a chromosome cut into slices. A fitness value and a population address come with the first slice. The block keeps the individual it received last. It pairs that stored individual (the older parent) with each new arrival (the newer parent). From the two it builds one offspring chromosome by uniform crossover, slice by slice, at one slice per clock. A pseudo-random mask decides, bit by bit, which parent supplies each offspring bit.

With every offspring the block forwards the address and fitness of the weaker of the two parents, so that the stages after it can decide which population slot to overwrite. Once a new arrival has been used, it replaces the stored individual and becomes the older parent for the next arrival. The stored chromosome lives in a slice buffer. Each slice is overwritten in the same cycle that it is read, so no second chromosome buffer is needed.

The output is a single register stage with valid/ready flow control. The block accepts an input slice only when its output register is free, or is being emptied in the same cycle.

Top module: `ga_xover_stage`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The first individual received after reset produces no output beats. It is only stored.
- R3: Each later individual produces exactly BEATS = ceil(CHROM_W/BEAT_W) output beats, one for each accepted input beat. Each output beat is presented in the clock cycle after its input beat is accepted. `out_last` is 1 on the final beat of each offspring and 0 on the others.
- R4: Offspring bit b of each beat is the newer parent's bit when mask bit b is 1, and the stored parent's bit of the same slice when it is 0. The mask is bits [BEAT_W-1:0] of a 16-bit shift register. That register is loaded with 0xACE1 at reset and steps once per produced beat, after its mask has been used, to {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R5: `in_fit` and `in_addr` are taken with slice 0 of an individual. `out_fit` and `out_addr` carry the parent with the smaller unsigned fitness. On equal fitness they carry the stored parent. The pair stays unchanged across all beats of one offspring.
- R6: Each used arrival becomes the stored parent (chromosome, fitness and address) for the next arrival.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and every output holds its value.
- R8: In the final beat, output bits at slice positions at or above CHROM_W-(BEATS-1)*BEAT_W are 0, whatever was driven on those input bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input slice present |
| in_ready | output | 1 | Block can take an input slice |
| in_data | input | BEAT_W | Chromosome slice, slice 0 first |
| in_fit | input | FIT_W | Fitness of the arriving individual, read with slice 0 |
| in_addr | input | ADDR_W | Population address of the arriving individual, read with slice 0 |
| out_valid | output | 1 | Offspring slice present |
| out_ready | input | 1 | Downstream takes the slice |
| out_data | output | BEAT_W | Offspring slice |
| out_last | output | 1 | Final slice of the offspring |
| out_fit | output | FIT_W | Fitness of the weaker parent |
| out_addr | output | ADDR_W | Address of the weaker parent |

## Verification
The bench builds the block with a 10-bit chromosome, 4-bit slices, 8-bit fitness and 4-bit addresses. That gives three beats per individual and a final slice with only two live bits, so the zeroing of the unused bits and the wrap of the slice index are both exercised on every offspring. The small slice width keeps the mask sequence easy to model in the bench. Fitness ties and strictly ordered pairs in both directions are all reached with a handful of individuals. A phase with periodic downstream stalls drives the hold path and the input stall together.

// File: rtl/ga_xover_pkg.sv
package ga_xover_pkg;

  localparam int MASK_SR_W = 16;
  localparam logic [MASK_SR_W-1:0] MASK_SR_SEED = 16'hACE1;

  typedef enum logic {
    PICK_STORED = 1'b0,
    PICK_NEW    = 1'b1
  } parent_pick_e;

  function automatic logic [MASK_SR_W-1:0] mask_sr_step(input logic [MASK_SR_W-1:0] s);
    return {s[MASK_SR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/ga_mask_lfsr.sv
module ga_mask_lfsr
  import ga_xover_pkg::*;
#(
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [BEAT_W-1:0] mask
);

  logic [MASK_SR_W-1:0] sr_q;
  logic [MASK_SR_W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (adv) sr_d = mask_sr_step(sr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= MASK_SR_SEED;
    else        sr_q <= sr_d;
  end

  assign mask = sr_q[BEAT_W-1:0];

  // R4: the mask source never locks up in the all-zero state
  assert_mask_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q != '0);

endmodule

// File: rtl/ga_slice_store.sv
module ga_slice_store #(
  parameter int BEAT_W = 8,
  parameter int BEATS  = 4,
  parameter int FIT_W  = 16,
  parameter int ADDR_W = 8,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BEAT_W-1:0] wr_data,
  input  logic              hdr_en,
  input  logic [FIT_W-1:0]  hdr_fit,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic              set_full,
  output logic [BEAT_W-1:0] rd_data,
  output logic [FIT_W-1:0]  old_fit,
  output logic [ADDR_W-1:0] old_addr,
  output logic              full
);

  logic [BEAT_W-1:0] slice_q [BEATS];
  logic [FIT_W-1:0]  fit_q;
  logic [ADDR_W-1:0] addr_q;
  logic              full_q;

  generate
    for (genvar s = 0; s < BEATS; s++) begin : g_slice
      always_ff @(posedge clk) begin
        if (wr_en && (idx == IDX_W'(s))) slice_q[s] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fit_q  <= '0;
      addr_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (hdr_en) begin
        fit_q  <= hdr_fit;
        addr_q <= hdr_addr;
      end
      if (set_full) full_q <= 1'b1;
    end
  end

  assign rd_data  = slice_q[idx];
  assign old_fit  = fit_q;
  assign old_addr = addr_q;
  assign full     = full_q;

  // R6: once an individual is held, the store never reports empty again
  assert_full_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> full_q);

endmodule

// File: rtl/ga_worse_pick.sv
module ga_worse_pick
  import ga_xover_pkg::*;
#(
  parameter int FIT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic [FIT_W-1:0]  old_fit,
  input  logic [ADDR_W-1:0] old_addr,
  input  logic [FIT_W-1:0]  new_fit,
  input  logic [ADDR_W-1:0] new_addr,
  output logic [FIT_W-1:0]  worse_fit,
  output logic [ADDR_W-1:0] worse_addr
);

  parent_pick_e pick;

  always_comb begin
    pick = (new_fit < old_fit) ? PICK_NEW : PICK_STORED;
    if (pick == PICK_NEW) begin
      worse_fit  = new_fit;
      worse_addr = new_addr;
    end else begin
      worse_fit  = old_fit;
      worse_addr = old_addr;
    end
  end

endmodule

// File: rtl/ga_xover_stage.sv
module ga_xover_stage #(
  parameter int CHROM_W = 32,
  parameter int BEAT_W  = 8,
  parameter int FIT_W   = 16,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BEAT_W-1:0] in_data,
  input  logic [FIT_W-1:0]  in_fit,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BEAT_W-1:0] out_data,
  output logic              out_last,
  output logic [FIT_W-1:0]  out_fit,
  output logic [ADDR_W-1:0] out_addr
);

  localparam int BEATS = (CHROM_W + BEAT_W - 1) / BEAT_W;
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int TAIL  = CHROM_W - (BEATS - 1) * BEAT_W;
  localparam logic [BEAT_W-1:0] KEEP = {BEAT_W{1'b1}} >> (BEAT_W - TAIL);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // handshake and slice position
  logic             accept, last_in, first_in, produce;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign accept   = in_valid && in_ready;
  assign last_in  = (idx_q == IDX_W'(BEATS - 1));
  assign first_in = (idx_q == '0);

  always_comb begin
    idx_d = idx_q;
    if (accept) idx_d = last_in ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) idx_q <= '0;
    else          idx_q <= idx_d;
  end

  // stored parent and mask source
  logic [BEAT_W-1:0] old_slice, mask;
  logic [FIT_W-1:0]  old_fit, worse_fit;
  logic [ADDR_W-1:0] old_addr, worse_addr;
  logic              have_old;

  assign produce = accept && have_old;

  ga_slice_store #(.BEAT_W(BEAT_W), .BEATS(BEATS), .FIT_W(FIT_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n_i),
    .wr_en(accept), .idx(idx_q), .wr_data(in_data),
    .hdr_en(accept && first_in), .hdr_fit(in_fit), .hdr_addr(in_addr),
    .set_full(accept && last_in),
    .rd_data(old_slice), .old_fit(old_fit), .old_addr(old_addr), .full(have_old)
  );

  ga_mask_lfsr #(.BEAT_W(BEAT_W)) u_mask (
    .clk(clk), .rst_n(rst_n_i), .adv(produce), .mask(mask)
  );

  ga_worse_pick #(.FIT_W(FIT_W), .ADDR_W(ADDR_W)) u_pick (
    .old_fit(old_fit), .old_addr(old_addr), .new_fit(in_fit), .new_addr(in_addr),
    .worse_fit(worse_fit), .worse_addr(worse_addr)
  );

  // per-bit uniform crossover
  logic [BEAT_W-1:0] mixed, mixed_trim;

  generate
    for (genvar b = 0; b < BEAT_W; b++) begin : g_mix
      assign mixed[b] = mask[b] ? in_data[b] : old_slice[b];
    end
  endgenerate

  assign mixed_trim = last_in ? (mixed & KEEP) : mixed;

  // output register
  logic              ov_q, ov_d, ol_q, ol_d;
  logic [BEAT_W-1:0] od_q, od_d;
  logic [FIT_W-1:0]  of_q, of_d;
  logic [ADDR_W-1:0] oa_q, oa_d;

  assign in_ready = !ov_q || out_ready;

  always_comb begin
    ov_d = ov_q;
    ol_d = ol_q;
    od_d = od_q;
    of_d = of_q;
    oa_d = oa_q;
    if (out_ready) ov_d = 1'b0;
    if (produce) begin
      ov_d = 1'b1;
      ol_d = last_in;
      od_d = mixed_trim;
      if (first_in) begin
        of_d = worse_fit;
        oa_d = worse_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ov_q <= 1'b0;
      ol_q <= 1'b0;
      od_q <= '0;
      of_q <= '0;
      oa_q <= '0;
    end else begin
      ov_q <= ov_d;
      ol_q <= ol_d;
      od_q <= od_d;
      of_q <= of_d;
      oa_q <= oa_d;
    end
  end

  assign out_valid = ov_q;
  assign out_last  = ol_q;
  assign out_data  = od_q;
  assign out_fit   = of_q;
  assign out_addr  = oa_q;

  // R7: a stalled output keeps every field
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    ov_q && !out_ready |=> ov_q && $stable(od_q) && $stable(ol_q) && $stable(of_q) && $stable(oa_q));

  // R2: nothing is presented before a stored parent exists
  assert_first_silent_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    ov_q |-> have_old);

  // R8: unused bits of the final slice leave as zero
  assert_tail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    ov_q && ol_q |-> ((od_q & ~KEEP) == '0));

  // R5: the reported fitness never exceeds either parent's fitness
  assert_worse_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    produce && first_in |=> (of_q <= $past(in_fit)) && (of_q <= $past(old_fit)));

  // R5: parent report is constant inside one offspring
  assert_hdr_steady_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    ov_q && out_ready && !ol_q |=> $stable(of_q) && $stable(oa_q));

  // R3: a produced slice is on the output one cycle later
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    produce |=> ov_q);

endmodule

// File: tb/ga_xover_stage_tb.sv
module ga_xover_stage_tb;

  localparam int N  = 10;
  localparam int M  = 4;
  localparam int FW = 8;
  localparam int AW = 4;
  localparam int NB = (N + M - 1) / M;
  localparam int TL = N - (NB - 1) * M;
  localparam logic [M-1:0] KEEPM = {M{1'b1}} >> (M - TL);
  localparam int EW = M + 1 + FW + AW;

  logic clk, rst_n;
  logic in_valid, in_ready, out_valid, out_ready, out_last;
  logic [M-1:0]  in_data, out_data;
  logic [FW-1:0] in_fit, out_fit;
  logic [AW-1:0] in_addr, out_addr;

  ga_xover_stage #(.CHROM_W(N), .BEAT_W(M), .FIT_W(FW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_fit(in_fit), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_fit(out_fit), .out_addr(out_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [EW-1:0] exp_q[$];

  // reference model state
  logic [NB*M-1:0] prev_chrom;
  logic [FW-1:0]   prev_fit;
  logic [AW-1:0]   prev_addr;
  logic            have_prev = 1'b0;
  logic [15:0]     sr = 16'hACE1;
  int              stall_mode = 0;
  int              cyc = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [NB*M-1:0] chrom, input logic [FW-1:0] fit, input logic [AW-1:0] addr, input int gap);
    logic [FW-1:0] wf;
    logic [AW-1:0] wa;
    wf = (fit < prev_fit) ? fit : prev_fit;   // tie keeps the stored parent (R5)
    wa = (fit < prev_fit) ? addr : prev_addr;
    for (int k = 0; k < NB; k++) begin
      bit acc;
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = chrom[k*M +: M];
        in_fit   = (k == 0) ? fit  : ~fit;
        in_addr  = (k == 0) ? addr : ~addr;
        #5;
        acc = in_ready;
        if (acc && have_prev) begin
          logic [M-1:0] msk, o, nw, xo;
          msk = sr[M-1:0];
          o   = prev_chrom[k*M +: M];
          nw  = chrom[k*M +: M];
          xo  = (msk & nw) | (~msk & o);      // R4
          if (k == NB - 1) xo = xo & KEEPM;   // R8
          exp_q.push_back({xo, (k == NB - 1), wf, wa});
          sr = {sr[14:0], sr[15] ^ sr[13] ^ sr[12] ^ sr[10]};
        end
        @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    prev_chrom = chrom;   // R6: this arrival is the next stored parent
    prev_fit   = fit;
    prev_addr  = addr;
    have_prev  = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  // downstream ready pattern
  always @(negedge clk) begin
    cyc++;
    out_ready <= (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  // monitor
  logic          held;
  logic [EW-1:0] held_v;
  initial begin
    held = 1'b0;
    forever begin
      @(negedge clk);
      #5;
      if (rst_n) begin
        if (held) begin
          check(out_valid && ({out_data, out_last, out_fit, out_addr} == held_v), "R7 hold",
                32'({out_data, out_last, out_fit, out_addr}), 32'(held_v));
          held = 1'b0;
        end
        if (out_valid && !out_ready) begin
          check(!in_ready, "R7 in_ready", 32'(in_ready), 32'd0);
          held   = 1'b1;
          held_v = {out_data, out_last, out_fit, out_addr};
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 R3 unexpected beat", 32'(out_data), 32'd0);
          end else begin
            logic [EW-1:0] e;
            e = exp_q.pop_front();
            check(out_data == e[EW-1 -: M], "R4 R6 data", 32'(out_data), 32'(e[EW-1 -: M]));
            check(out_last == e[FW+AW], "R3 last", 32'(out_last), 32'(e[FW+AW]));
            check(out_fit == e[AW +: FW], "R5 fit", 32'(out_fit), 32'(e[AW +: FW]));
            check(out_addr == e[AW-1:0], "R5 addr", 32'(out_addr), 32'(e[AW-1:0]));
            if (out_last)
              check((out_data & ~KEEPM) == '0, "R8 tail", 32'(out_data), 32'(out_data & KEEPM));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_fit = '0; in_addr = '0;
    prev_chrom = '0; prev_fit = '0; prev_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #5;
    check(!out_valid, "R1 out_valid", 32'(out_valid), 32'd0);
    check(in_ready, "R1 in_ready", 32'(in_ready), 32'd1);

    // R2: first individual is silent
    send(12'hF3A, 8'd50, 4'd1, 6);
    #5;
    check(!out_valid, "R2 silent", 32'(out_valid), 32'd0);
    check(exp_q.size() == 0, "R2 queue", 32'(exp_q.size()), 32'd0);

    // R4 R5: ordered pairs both ways, a tie, identical and complementary parents
    send(12'h0C5, 8'd30, 4'd2, 0);   // new lower
    send(12'hAAA, 8'd90, 4'd3, 0);   // stored lower
    send(12'h555, 8'd90, 4'd4, 1);   // tie
    send(12'h555, 8'd200, 4'd5, 0);  // identical chromosomes
    send(12'hFFF, 8'd0, 4'd6, 2);
    send(12'h000, 8'd255, 4'd7, 0);

    // R7: downstream stalls
    stall_mode = 1;
    for (int i = 0; i < 8; i++)
      send(12'(i * 12'h2B7 + 12'h19), 8'(i * 37 + 5), 4'(i + 8), i % 2);
    stall_mode = 0;

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R3 all beats delivered", 32'(exp_q.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule